// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block drives an 8-bit large-page NAND flash device over a plain strobe bus. Each bus transfer lasts one clock cycle: a write strobe with a two-bit latch selector marks a command byte, an address byte or a data byte, and a read strobe fetches one byte from the device. The host starts one of three operations with a single-cycle start pulse, an operation code and a page number: read a whole page with its spare area, program a whole page with its spare area, or erase the block that holds the page.

Every operation first polls the status register until the device reports ready, issuing a device reset when a round of polls times out. It then sends the command and address cycles, moves the data, and, for program and erase, polls status again and reports pass, fail or timeout. Page data to be programmed is pulled from the host one byte per request cycle, and read data is handed back as a byte stream with a valid flag. All waits are counted in clock cycles set by parameters.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, chip enable (active low) is high, both bus strobes and the done output are low.
- R2: Every bus transfer is a one-cycle strobe. `nand_lat_o` = 2'b01 marks a command byte, 2'b10 an address byte, 2'b00 a data byte; the latch selector is non-zero only with the write strobe, and the write and read strobes are never high together.
- R3: Each operation starts with command 0x70 followed by status reads; bit 6 of status means ready. If POLL_MAX reads all show busy, command 0xFF is issued and the 0x70 poll round is repeated.
- R4: Op code 0 (read) sends command 0x00, five address bytes (two zero column bytes, then the page number least significant byte first), command 0x30, waits at least READ_WAIT+1 cycles, then performs PAGE_BYTES+SPARE_BYTES data reads delivered in order on `rdata_o` with `rdata_vld_o`, and ends with code 0.
- R5: Op code 1 (program) sends command 0x80, five address bytes (two zero column bytes, then the page LSB first), PAGE_BYTES+SPARE_BYTES data bytes taken from `wdata_i` in the cycles where `wdata_req_o` is high, then command 0x10.
- R6: Op code 2 (erase) sends command 0x60, three row address bytes of the page LSB first, then command 0xD0.
- R7: After program or erase, the block waits, sends 0x70 and reads status at most POLL_MAX times, with at least POLL_GAP idle cycles before each read.
- R8: The result code on `err_code_o` is 0 when ready is seen with bit 0 clear, 1 when ready is seen with bit 0 set, and 2 when no ready appears within POLL_MAX reads; `err_o` is high exactly when the code is non-zero, and both are only non-zero in the done cycle.
- R9: Chip enable is low from the first bus cycle of an operation until its last bus cycle, high in the done cycle and whenever idle; no strobe occurs while it is high.
- R10: A start while an operation runs, or a start with op code 3, is ignored; `done_o` is a one-cycle pulse, once per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| op_i | input | 2 | Operation: 0 read, 1 program, 2 erase |
| page_i | input | 8*ROW_BYTES | Page number |
| wdata_i | input | 8 | Program data byte from host |
| wdata_req_o | output | 1 | Host byte consumed this cycle |
| rdata_o | output | 8 | Read data byte |
| rdata_vld_o | output | 1 | Read data valid |
| done_o | output | 1 | Operation finished (one cycle) |
| err_o | output | 1 | Operation ended with an error |
| err_code_o | output | 2 | 0 ok, 1 device fail, 2 timeout |
| nand_ce_n_o | output | 1 | Device chip enable, active low |
| nand_we_o | output | 1 | Write strobe |
| nand_rd_o | output | 1 | Read strobe |
| nand_lat_o | output | 2 | Latch select: 01 command, 10 address |
| nand_dq_o | output | 8 | Byte to device |
| nand_dq_i | input | 8 | Byte from device |

## Verification
A wrong sequencer state shows at the device bus on the very next transfer: a missing or reordered command or address byte, a data byte marked as a command, or a strobe with chip enable released. A poll counter or timer fault shows as a status read taken too early, a wrong read count before the result, or a wrong code in the done cycle. The bench's device model logs every write with its latch kind and cycle, counts status reads since the last 0x70, and answers with programmable busy and fail behaviour, so each such fault appears as a log mismatch within one operation.

// File: rtl/nand_page_seq.sv
module nand_page_seq #(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ROW_BYTES   = 3,
  parameter int READ_WAIT   = 10000,
  parameter int PROG_WAIT   = 20000,
  parameter int ERASE_WAIT  = 400000,
  parameter int POLL_GAP    = 2000,
  parameter int POLL_MAX    = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [1:0]             op_i,
  input  logic [8*ROW_BYTES-1:0] page_i,
  input  logic [7:0]             wdata_i,
  output logic                   wdata_req_o,
  output logic [7:0]             rdata_o,
  output logic                   rdata_vld_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [1:0]             err_code_o,
  output logic                   nand_ce_n_o,
  output logic                   nand_we_o,
  output logic                   nand_rd_o,
  output logic [1:0]             nand_lat_o,
  output logic [7:0]             nand_dq_o,
  input  logic [7:0]             nand_dq_i
);

  localparam int XFER   = PAGE_BYTES + SPARE_BYTES;
  localparam int CNT_W  = $clog2(XFER + ROW_BYTES + 3);
  localparam int WMAX1  = (READ_WAIT > PROG_WAIT) ? READ_WAIT : PROG_WAIT;
  localparam int WMAX2  = (WMAX1 > ERASE_WAIT) ? WMAX1 : ERASE_WAIT;
  localparam int TMAX   = (WMAX2 > POLL_GAP) ? WMAX2 : POLL_GAP;
  localparam int TMR_W  = $clog2(TMAX + 2);
  localparam int PW     = $clog2(POLL_MAX + 2);

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;

  localparam logic [1:0] LAT_CMD  = 2'b01;
  localparam logic [1:0] LAT_ADR  = 2'b10;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_CMD, S_PRE_POLL, S_PRE_RST, S_OP_CMD, S_ADDR,
    S_WDATA, S_GO_CMD, S_WAIT, S_RDATA, S_POST_CMD, S_POST_POLL
  } st_t;

  st_t                   state;
  logic [1:0]            op_q;
  logic [8*ROW_BYTES-1:0] page_q;
  logic [CNT_W-1:0]      cnt;
  logic [TMR_W-1:0]      tmr;
  logic [PW-1:0]         polls;
  logic                  done_q;
  logic [1:0]            code_q;
  logic [7:0]            rdata_q;
  logic                  rvld_q;

  logic [CNT_W-1:0]      row_idx;
  logic [8*ROW_BYTES-1:0] row_sh;
  logic [7:0]            addr_byte;
  logic [CNT_W-1:0]      addr_last;
  logic [7:0]            op_cmd;
  logic [7:0]            go_cmd;
  logic                  rdy_bit;

  assign row_idx   = (op_q == OP_ERASE) ? cnt : cnt - CNT_W'(2);
  assign row_sh    = page_q >> {row_idx, 3'b000};
  assign addr_byte = (op_q != OP_ERASE && cnt < CNT_W'(2)) ? 8'h00 : row_sh[7:0];
  assign addr_last = (op_q == OP_ERASE) ? CNT_W'(ROW_BYTES - 1) : CNT_W'(ROW_BYTES + 1);
  assign op_cmd    = (op_q == OP_READ) ? 8'h00 : (op_q == OP_PROG) ? 8'h80 : 8'h60;
  assign go_cmd    = (op_q == OP_READ) ? 8'h30 : (op_q == OP_PROG) ? 8'h10 : 8'hD0;
  assign rdy_bit   = nand_dq_i[6];

  assign nand_ce_n_o = (state == S_IDLE);
  assign done_o      = done_q;
  assign err_code_o  = code_q;
  assign err_o       = |code_q;
  assign rdata_o     = rdata_q;
  assign rdata_vld_o = rvld_q;

  always_comb begin
    nand_we_o   = 1'b0;
    nand_rd_o   = 1'b0;
    nand_lat_o  = 2'b00;
    nand_dq_o   = 8'h00;
    wdata_req_o = 1'b0;
    case (state)
      S_PRE_CMD, S_POST_CMD: begin nand_we_o = 1'b1; nand_lat_o = LAT_CMD; nand_dq_o = 8'h70; end
      S_PRE_RST:  begin nand_we_o = 1'b1; nand_lat_o = LAT_CMD; nand_dq_o = 8'hFF; end
      S_OP_CMD:   begin nand_we_o = 1'b1; nand_lat_o = LAT_CMD; nand_dq_o = op_cmd; end
      S_ADDR:     begin nand_we_o = 1'b1; nand_lat_o = LAT_ADR; nand_dq_o = addr_byte; end
      S_GO_CMD:   begin nand_we_o = 1'b1; nand_lat_o = LAT_CMD; nand_dq_o = go_cmd; end
      S_WDATA:    begin nand_we_o = 1'b1; nand_dq_o = wdata_i; wdata_req_o = 1'b1; end
      S_RDATA:    nand_rd_o = 1'b1;
      S_PRE_POLL, S_POST_POLL: nand_rd_o = (tmr == '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_READ;
      page_q  <= '0;
      cnt     <= '0;
      tmr     <= '0;
      polls   <= '0;
      done_q  <= 1'b0;
      code_q  <= RES_OK;
      rdata_q <= 8'h00;
      rvld_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      code_q <= RES_OK;
      rvld_q <= 1'b0;
      case (state)
        S_IDLE:
          if (start_i && op_i != 2'd3) begin
            op_q   <= op_i;
            page_q <= page_i;
            state  <= S_PRE_CMD;
          end
        S_PRE_CMD: begin
          tmr   <= TMR_W'(POLL_GAP);
          polls <= '0;
          state <= S_PRE_POLL;
        end
        S_PRE_POLL:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (rdy_bit) state <= S_OP_CMD;
          else if (polls == PW'(POLL_MAX - 1)) state <= S_PRE_RST;
          else begin
            polls <= polls + 1'b1;
            tmr   <= TMR_W'(POLL_GAP);
          end
        S_PRE_RST: state <= S_PRE_CMD;
        S_OP_CMD: begin
          cnt   <= '0;
          state <= S_ADDR;
        end
        S_ADDR:
          if (cnt == addr_last) begin
            cnt   <= '0;
            state <= (op_q == OP_PROG) ? S_WDATA : S_GO_CMD;
          end else cnt <= cnt + 1'b1;
        S_WDATA:
          if (cnt == CNT_W'(XFER - 1)) state <= S_GO_CMD;
          else cnt <= cnt + 1'b1;
        S_GO_CMD: begin
          tmr   <= (op_q == OP_READ) ? TMR_W'(READ_WAIT) :
                   (op_q == OP_PROG) ? TMR_W'(PROG_WAIT) : TMR_W'(ERASE_WAIT);
          cnt   <= '0;
          state <= S_WAIT;
        end
        S_WAIT:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else state <= (op_q == OP_READ) ? S_RDATA : S_POST_CMD;
        S_RDATA: begin
          rdata_q <= nand_dq_i;
          rvld_q  <= 1'b1;
          if (cnt == CNT_W'(XFER - 1)) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_POST_CMD: begin
          tmr   <= TMR_W'(POLL_GAP);
          polls <= '0;
          state <= S_POST_POLL;
        end
        S_POST_POLL:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (rdy_bit) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            code_q <= nand_dq_i[0] ? RES_FAIL : RES_OK;
          end else if (polls == PW'(POLL_MAX - 1)) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            code_q <= RES_TMO;
          end else begin
            polls <= polls + 1'b1;
            tmr   <= TMR_W'(POLL_GAP);
          end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done_o,
  input logic       err_o,
  input logic       wdata_req_o,
  input logic       rdata_vld_o,
  input logic       nand_ce_n_o,
  input logic       nand_we_o,
  input logic       nand_rd_o,
  input logic [1:0] nand_lat_o
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_we_o && nand_rd_o));

  // R2
  latch_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_lat_o != 2'b00) |-> (nand_we_o && $onehot0(nand_lat_o)));

  // R9
  ce_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_we_o || nand_rd_o) |-> !nand_ce_n_o);

  // R9
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n_o |=> (!nand_ce_n_o || done_o));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> nand_ce_n_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R5
  wreq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_req_o |-> (nand_we_o && nand_lat_o == 2'b00));

  // R4
  rvld_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld_o |-> $past(nand_rd_o));

endmodule

bind nand_page_seq nand_page_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .err_o(err_o),
  .wdata_req_o(wdata_req_o), .rdata_vld_o(rdata_vld_o),
  .nand_ce_n_o(nand_ce_n_o), .nand_we_o(nand_we_o),
  .nand_rd_o(nand_rd_o), .nand_lat_o(nand_lat_o)
);

// File: tb/nand_page_seq_tb.sv
`timescale 1ns/1ps
module nand_page_seq_tb_top;
  localparam int PB = 16, SB = 4, XF = PB + SB;
  localparam int RW = 6, PWT = 9, EW = 12, GAP = 3, PMAX = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0;

  logic start_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [23:0] page_i = '0;
  logic [7:0] wdata_i;
  logic wdata_req_o, rdata_vld_o, done_o, err_o;
  logic [7:0] rdata_o;
  logic [1:0] err_code_o;
  logic nand_ce_n_o, nand_we_o, nand_rd_o;
  logic [1:0] nand_lat_o;
  logic [7:0] nand_dq_o, nand_dq_i;

  nand_page_seq #(.PAGE_BYTES(PB), .SPARE_BYTES(SB), .ROW_BYTES(3),
    .READ_WAIT(RW), .PROG_WAIT(PWT), .ERASE_WAIT(EW), .POLL_GAP(GAP), .POLL_MAX(PMAX))
  dut_i (.clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .page_i(page_i),
    .wdata_i(wdata_i), .wdata_req_o(wdata_req_o), .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o), .nand_ce_n_o(nand_ce_n_o),
    .nand_we_o(nand_we_o), .nand_rd_o(nand_rd_o), .nand_lat_o(nand_lat_o),
    .nand_dq_o(nand_dq_o), .nand_dq_i(nand_dq_i));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // device model
  logic clr = 1'b0;
  int cfg_pre_busy = 0, cfg_post_busy = 0;
  logic cfg_fail = 1'b0;
  int busy_left = 0;
  logic post_ph = 1'b0, data_mode = 1'b0;
  logic [7:0] row0 = 8'h00;
  int acnt = 0, didx = 0, widx = 0;
  int lg_n = 0;
  logic [1:0] lg_lat [0:63];
  logic [7:0] lg_val [0:63];
  int lg_cyc [0:63];
  int st_since70 = 0, prev_st_cyc = 0, min_st_gap = 1000000;
  int go_cyc = 0, first_data_cyc = -1, bad_ce = 0;
  int rn = 0;
  logic [7:0] rbuf [0:63];
  logic [7:0] stat_val;

  assign stat_val  = (busy_left != 0) ? 8'h80 : (8'hC0 | {7'd0, post_ph & cfg_fail});
  assign nand_dq_i = data_mode ? (row0 + 8'(didx * 3)) : stat_val;
  assign wdata_i   = 8'h3C ^ 8'(widx * 5);

  always @(posedge clk) begin
    if (clr) begin
      busy_left <= cfg_pre_busy; post_ph <= 1'b0; data_mode <= 1'b0;
      acnt <= 0; didx <= 0; widx <= 0; lg_n <= 0; st_since70 <= 0;
      min_st_gap <= 1000000; first_data_cyc <= -1; bad_ce <= 0; rn <= 0;
    end else begin
      if ((nand_we_o || nand_rd_o) && nand_ce_n_o) bad_ce <= bad_ce + 1;
      if (nand_we_o) begin
        if (lg_n < 64) begin
          lg_lat[lg_n] <= nand_lat_o; lg_val[lg_n] <= nand_dq_o; lg_cyc[lg_n] <= cyc;
        end
        lg_n <= lg_n + 1;
        if (nand_lat_o == 2'b10) begin
          if (acnt == 2) row0 <= nand_dq_o;
          acnt <= acnt + 1;
        end
        if (nand_lat_o == 2'b01) begin
          acnt <= 0;
          case (nand_dq_o)
            8'h70: begin data_mode <= 1'b0; st_since70 <= 0; prev_st_cyc <= cyc; end
            8'h30: begin data_mode <= 1'b1; didx <= 0; go_cyc <= cyc; end
            8'h10, 8'hD0: begin busy_left <= cfg_post_busy; post_ph <= 1'b1; end
            8'hFF: busy_left <= 0;
            default: ;
          endcase
        end
      end
      if (nand_rd_o) begin
        if (data_mode) begin
          if (didx == 0) first_data_cyc <= cyc;
          didx <= didx + 1;
        end else begin
          st_since70 <= st_since70 + 1;
          if (cyc - prev_st_cyc < min_st_gap) min_st_gap <= cyc - prev_st_cyc;
          prev_st_cyc <= cyc;
          if (busy_left > 0) busy_left <= busy_left - 1;
        end
      end
      if (wdata_req_o) widx <= widx + 1;
      if (rdata_vld_o) begin
        if (rn < 64) rbuf[rn] <= rdata_o;
        rn <= rn + 1;
      end
    end
  end

  int done_cnt = 0, last_code = 0, last_err = 0;
  always @(negedge clk) if (done_o) begin
    done_cnt <= done_cnt + 1; last_code <= int'(err_code_o); last_err <= int'(err_o);
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_log(input int i, input logic [1:0] lat, input logic [7:0] v, input string req);
    chk(lg_lat[i] == lat && lg_val[i] == v, req, int'({lg_lat[i], lg_val[i]}), int'({lat, v}));
  endtask

  task automatic setup(input int pre, input int post, input bit fail);
    cfg_pre_busy = pre; cfg_post_busy = post; cfg_fail = fail;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [23:0] pg);
    int d0;
    d0 = done_cnt;
    @(negedge clk); op_i = op; page_i = pg; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (done_cnt == d0 && cyc < LIMIT) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(nand_ce_n_o && !nand_we_o && !nand_rd_o && !done_o, "R1",
        int'({nand_ce_n_o, nand_we_o, nand_rd_o, done_o}), 8);
  endtask

  task automatic t_read(input logic [23:0] pg);
    setup(0, 0, 1'b0);
    run_op(2'd0, pg);
    chk(lg_n == 8, "R4 write count", lg_n, 8);
    chk_log(0, 2'b01, 8'h70, "R3 status cmd");
    chk_log(1, 2'b01, 8'h00, "R4 read cmd");
    chk_log(2, 2'b10, 8'h00, "R4 col0");
    chk_log(3, 2'b10, 8'h00, "R4 col1");
    chk_log(4, 2'b10, pg[7:0], "R4 row0");
    chk_log(5, 2'b10, pg[15:8], "R4 row1");
    chk_log(6, 2'b10, pg[23:16], "R4 row2");
    chk_log(7, 2'b01, 8'h30, "R4 go cmd");
    chk(first_data_cyc - go_cyc >= RW + 1, "R4 read wait", first_data_cyc - go_cyc, RW + 1);
    chk(rn == XF, "R4 byte count", rn, XF);
    for (int i = 0; i < XF; i++)
      if (rbuf[i] != pg[7:0] + 8'(i * 3))
        chk(1'b0, "R4 data", int'(rbuf[i]), int'(pg[7:0] + 8'(i * 3)));
    chk(last_code == 0 && last_err == 0, "R8 read ok", last_code, 0);
    chk(bad_ce == 0 && nand_ce_n_o, "R9 ce", bad_ce, 0);
  endtask

  task automatic t_prog(input logic [23:0] pg, input bit fail, input int post);
    setup(0, post, fail);
    run_op(2'd1, pg);
    chk(lg_n == 9 + XF, "R5 write count", lg_n, 9 + XF);
    chk_log(1, 2'b01, 8'h80, "R5 prog cmd");
    chk_log(2, 2'b10, 8'h00, "R5 col0");
    chk_log(3, 2'b10, 8'h00, "R5 col1");
    chk_log(4, 2'b10, pg[7:0], "R5 row0");
    chk_log(6, 2'b10, pg[23:16], "R5 row2");
    for (int i = 0; i < XF; i++)
      if (lg_lat[7 + i] != 2'b00 || lg_val[7 + i] != (8'h3C ^ 8'(i * 5)))
        chk(1'b0, "R5 data", int'(lg_val[7 + i]), int'(8'h3C ^ 8'(i * 5)));
    chk_log(7 + XF, 2'b01, 8'h10, "R5 start cmd");
    chk_log(8 + XF, 2'b01, 8'h70, "R7 poll cmd");
    chk(lg_cyc[8 + XF] - lg_cyc[7 + XF] >= PWT + 1, "R7 prog wait",
        lg_cyc[8 + XF] - lg_cyc[7 + XF], PWT + 1);
    chk(st_since70 == post + 1, "R7 poll count", st_since70, post + 1);
    chk(min_st_gap >= GAP + 1, "R7 poll spacing", min_st_gap, GAP + 1);
    chk(last_code == (fail ? 1 : 0) && last_err == (fail ? 1 : 0), "R8 prog code",
        last_code, fail ? 1 : 0);
  endtask

  task automatic t_erase(input logic [23:0] pg, input int post, input int exp_code);
    setup(0, post, 1'b0);
    run_op(2'd2, pg);
    chk(lg_n == 7, "R6 write count", lg_n, 7);
    chk_log(1, 2'b01, 8'h60, "R6 erase cmd");
    chk_log(2, 2'b10, pg[7:0], "R6 row0");
    chk_log(3, 2'b10, pg[15:8], "R6 row1");
    chk_log(4, 2'b10, pg[23:16], "R6 row2");
    chk_log(5, 2'b01, 8'hD0, "R6 go cmd");
    chk(lg_cyc[6] - lg_cyc[5] >= EW + 1, "R7 erase wait", lg_cyc[6] - lg_cyc[5], EW + 1);
    chk(last_code == exp_code && last_err == (exp_code != 0), "R8 erase code", last_code, exp_code);
    if (exp_code == 2)
      chk(st_since70 == PMAX, "R7 R8 timeout polls", st_since70, PMAX);
    chk(min_st_gap >= GAP + 1, "R7 spacing", min_st_gap, GAP + 1);
  endtask

  task automatic t_pre_busy(input logic [23:0] pg);
    setup(PMAX + 2, 0, 1'b0);
    run_op(2'd2, pg);
    chk_log(0, 2'b01, 8'h70, "R3 first poll");
    chk_log(1, 2'b01, 8'hFF, "R3 reset cmd");
    chk_log(2, 2'b01, 8'h70, "R3 second poll");
    chk_log(3, 2'b01, 8'h60, "R3 op after ready");
    chk(lg_cyc[1] - lg_cyc[0] > PMAX * (GAP + 1), "R3 full round", lg_cyc[1] - lg_cyc[0],
        PMAX * (GAP + 1) + 1);
    chk(last_code == 0, "R3 result", last_code, 0);
  endtask

  task automatic t_ignore(input logic [23:0] pg);
    int d0;
    setup(0, 0, 1'b0);
    d0 = done_cnt;
    @(negedge clk); op_i = 2'd1; page_i = pg; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    op_i = 2'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (done_cnt == d0 && cyc < LIMIT) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10 one done", done_cnt - d0, 1);
    chk(lg_n == 9 + XF, "R10 no second op", lg_n, 9 + XF);
    chk_log(1, 2'b01, 8'h80, "R10 op kept");
    chk(nand_ce_n_o, "R10 idle after", int'(nand_ce_n_o), 1);
    setup(0, 0, 1'b0);
    d0 = done_cnt;
    @(negedge clk); op_i = 2'd3; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 && lg_n == 0 && nand_ce_n_o, "R10 op3 ignored", lg_n, 0);
  endtask

  initial begin
    wait (cyc >= LIMIT);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(24'h123456);
    t_read(24'hA0B1C2);
    t_prog(24'h00F00D, 1'b0, 0);
    t_prog(24'h0102FE, 1'b1, 3);
    t_erase(24'h345678, 2, 0);
    t_erase(24'h0000FF, 1000, 2);
    t_pre_busy(24'h0A0B0C);
    t_ignore(24'h111111);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule